// File: doc/BRIEF.md
# Background Pixel Shifter Pipeline

This block turns fetched background pattern bytes into a stream of 2-bit palette indices, one per dot. It holds one 16-bit shift register per bit plane. Each register shifts toward its most significant bit once per dot while a fetch window is open, and the pixel bit is taken from the top. Every eighth dot a freshly fetched pattern byte is merged into the low half. The two top bits form a palette address, which is registered on the shift edge. The drawn pixel follows one dot later, so output lags the shift by a fixed two-dot lookup delay.

The caller supplies the current dot number of the scanline (0 to 340), the pattern bytes of both planes, and a background-enable bit. A small window state machine decides on which dots the registers move. It has three states. `WIN_IDLE` holds the registers. `WIN_DRAW` covers the visible run of dots 2 to 257. `WIN_PREFETCH` covers dots 322 to 337, where the first two tiles of the next line are primed. The transitions are:
- `IDLE->DRAW` on the edge while dot is 1.
- `DRAW->IDLE` on the edge while dot is 257.
- `IDLE->PREFETCH` on the edge while dot is 321.
- `PREFETCH->IDLE` on the edge while dot is 337.

Clearing background enable blanks only the drawn pixel. Shifting and reloads carry on.

Top module: `bg_pixel_shifter`

Timing convention: a value registered on the rising edge while `dot` equals d is visible on the outputs during dot d+1.

## Requirements
- R1: While reset is asserted, `pal_addr`, `pix_idx` and `pix_valid` are all 0, and both plane registers are cleared.
- R2: The plane registers change only on edges where `dot` is in 2..257 or 322..337. On every other dot they hold their value.
- R3: A shift moves each plane register one place toward bit 15 and fills bit 0 with 0. The pixel bit of a plane is its bit 15 before the shift.
- R4: On a shift edge where `dot` mod 8 equals 1, each register takes the following value:
  - bits 15..8 take the old bits 14..7;
  - bits 7..0 take that plane's pattern byte.
- R5: The palette index is {high-plane bit, low-plane bit}. Both set gives 3, both clear gives 0, and only the low plane set gives 1.
- R6: `pal_addr` is captured on the shift edge, and `pix_idx` follows on the next edge. A 0x80 byte in both planes loaded at dot 329 therefore shows index 3 during dot 4 of the next line, and index 0 for the seven dots after it.
- R7: `pix_valid` is high exactly one dot after each `pal_addr` capture. While it is low, `pix_idx` is 0.
- R8: When `bg_en` is low on an edge, the `pix_idx` registered there is 0. Shifting, reloads and `pal_addr` are unaffected.
- R9: The window state machine is always in exactly one of its three states and follows only the four listed transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot | input | 9 | Current dot within the scanline, 0..340 |
| pat_lo | input | 8 | Fetched low-plane pattern byte |
| pat_hi | input | 8 | Fetched high-plane pattern byte |
| bg_en | input | 1 | Background draw enable |
| pal_addr | output | 2 | Registered palette address {hi, lo} |
| pix_idx | output | 2 | Drawn background palette index |
| pix_valid | output | 1 | Marks a drawn pixel on `pix_idx` |

## Verification
The first pattern primes a single 0x80 byte in both planes during the prefetch window. This shows whether the index-3 pixel lands on exactly dot 4, which separates a correct two-stage lag from an off-by-one load or shift edge. The following line is all-zero, which shows that the zero fill and the top-bit tap leave no stray pixel behind. Dot-dependent pseudo-random bytes in both planes, which differ between the planes, check the shift-and-merge on every reload and would expose swapped planes or a wrong merge boundary. A line with `bg_en` toggling every 16 dots then shows that blanking forces index 0 without disturbing the pixels that follow it.

// File: rtl/bg_pix_pkg.sv
package bg_pix_pkg;

    typedef enum logic [2:0] {
        WIN_IDLE     = 3'b001,
        WIN_DRAW     = 3'b010,
        WIN_PREFETCH = 3'b100
    } win_state_e;

    localparam int PIX_IDX_W = 2;

endpackage

// File: rtl/bg_win_fsm.sv
module bg_win_fsm
    import bg_pix_pkg::*;
#(
    parameter int DOT_W      = 9,
    parameter int TILE_W     = 8,
    parameter int DRAW_FIRST = 2,
    parameter int DRAW_LAST  = 257,
    parameter int PRE_FIRST  = 322,
    parameter int PRE_LAST   = 337
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DOT_W-1:0] dot,
    output win_state_e       state,
    output logic             shift_en,
    output logic             reload_en
);
    localparam int PH_W = $clog2(TILE_W);
    localparam logic [DOT_W-1:0] DRAW_ARM = DOT_W'(DRAW_FIRST - 1);
    localparam logic [DOT_W-1:0] DRAW_END = DOT_W'(DRAW_LAST);
    localparam logic [DOT_W-1:0] PRE_ARM  = DOT_W'(PRE_FIRST - 1);
    localparam logic [DOT_W-1:0] PRE_END  = DOT_W'(PRE_LAST);

    win_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_IDLE: begin
                if (dot == DRAW_ARM)     state_d = WIN_DRAW;
                else if (dot == PRE_ARM) state_d = WIN_PREFETCH;
            end
            WIN_DRAW:     if (dot == DRAW_END) state_d = WIN_IDLE;
            WIN_PREFETCH: if (dot == PRE_END)  state_d = WIN_IDLE;
            default:      state_d = WIN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WIN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        shift_en  = (state_q != WIN_IDLE);
        reload_en = shift_en && (dot[PH_W-1:0] == PH_W'(1));
    end

    assign state = state_q;

endmodule

// File: rtl/bg_plane_shift.sv
module bg_plane_shift #(
    parameter int TILE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                reload_en,
    input  logic [TILE_W-1:0]   pat,
    output logic [2*TILE_W-1:0] plane_q
);
    localparam int SW = 2 * TILE_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plane_q <= '0;
        end else if (reload_en) begin
            plane_q <= {plane_q[SW-2:TILE_W-1], pat};
        end else if (shift_en) begin
            plane_q <= {plane_q[SW-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/bg_out_pipe.sv
module bg_out_pipe
    import bg_pix_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 tap_lo,
    input  logic                 tap_hi,
    input  logic                 bg_en,
    output logic [PIX_IDX_W-1:0] pal_addr,
    output logic [PIX_IDX_W-1:0] pix_idx,
    output logic                 pix_valid
);
    logic pal_v;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pal_addr  <= '0;
            pal_v     <= 1'b0;
            pix_idx   <= '0;
            pix_valid <= 1'b0;
        end else begin
            if (shift_en) pal_addr <= {tap_hi, tap_lo};
            pal_v     <= shift_en;
            pix_idx   <= (bg_en && pal_v) ? pal_addr : '0;
            pix_valid <= pal_v;
        end
    end

endmodule

// File: rtl/bg_pixel_shifter.sv
module bg_pixel_shifter
    import bg_pix_pkg::*;
#(
    parameter int DOT_W      = 9,
    parameter int TILE_W     = 8,
    parameter int DRAW_FIRST = 2,
    parameter int DRAW_LAST  = 257,
    parameter int PRE_FIRST  = 322,
    parameter int PRE_LAST   = 337
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DOT_W-1:0]  dot,
    input  logic [TILE_W-1:0] pat_lo,
    input  logic [TILE_W-1:0] pat_hi,
    input  logic              bg_en,
    output logic [1:0]        pal_addr,
    output logic [1:0]        pix_idx,
    output logic              pix_valid
);
    localparam int SW     = 2 * TILE_W;
    localparam int PLANES = 2;

    win_state_e                         win_q;
    logic                               shift_en;
    logic                               reload_en;
    logic [PLANES-1:0][TILE_W-1:0]      pat_bus;
    logic [PLANES-1:0][SW-1:0]          plane_q;
    logic [PLANES-1:0]                  taps;

    assign pat_bus = {pat_hi, pat_lo};

    bg_win_fsm #(
        .DOT_W(DOT_W), .TILE_W(TILE_W),
        .DRAW_FIRST(DRAW_FIRST), .DRAW_LAST(DRAW_LAST),
        .PRE_FIRST(PRE_FIRST), .PRE_LAST(PRE_LAST)
    ) win_i (
        .clk(clk), .rst_n(rst_n), .dot(dot),
        .state(win_q), .shift_en(shift_en), .reload_en(reload_en)
    );

    for (genvar g = 0; g < PLANES; g++) begin : g_plane
        bg_plane_shift #(.TILE_W(TILE_W)) plane_i (
            .clk(clk), .rst_n(rst_n),
            .shift_en(shift_en), .reload_en(reload_en),
            .pat(pat_bus[g]), .plane_q(plane_q[g])
        );
        assign taps[g] = plane_q[g][SW-1];
    end

    bg_out_pipe out_i (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .tap_lo(taps[0]), .tap_hi(taps[1]), .bg_en(bg_en),
        .pal_addr(pal_addr), .pix_idx(pix_idx), .pix_valid(pix_valid)
    );

endmodule

// File: rtl/bg_pixel_shifter_chk.sv
module bg_pixel_shifter_chk
    import bg_pix_pkg::*;
#(
    parameter int DOT_W      = 9,
    parameter int TILE_W     = 8,
    parameter int DRAW_FIRST = 2,
    parameter int PRE_FIRST  = 322
) (
    input logic                clk,
    input logic                rst_n,
    input logic [DOT_W-1:0]    dot,
    input logic [TILE_W-1:0]   pat_lo,
    input logic [TILE_W-1:0]   pat_hi,
    input logic                bg_en,
    input logic [1:0]          pal_addr,
    input logic [1:0]          pix_idx,
    input logic                pix_valid,
    input logic [2*TILE_W-1:0] plane_lo,
    input logic [2*TILE_W-1:0] plane_hi,
    input win_state_e          state,
    input logic                shift_en,
    input logic                reload_en
);
    localparam int SW = 2 * TILE_W;

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WIN_IDLE) |=> ($stable(plane_lo) && $stable(plane_hi)));

    assert_shift_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !reload_en) |=>
            (plane_lo[SW-1:1] == $past(plane_lo[SW-2:0])) && !plane_lo[0] &&
            (plane_hi[SW-1:1] == $past(plane_hi[SW-2:0])) && !plane_hi[0]);

    assert_reload_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reload_en |=> (plane_lo[TILE_W-1:0] == $past(pat_lo)) &&
                      (plane_hi[TILE_W-1:0] == $past(pat_hi)));

    assert_pipe_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bg_en |=> (!pix_valid || pix_idx == $past(pal_addr)));

    assert_invalid_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> (pix_idx == 2'b00));

    assert_valid_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_valid) |-> (dot == DOT_W'(DRAW_FIRST + 2) || dot == DOT_W'(PRE_FIRST + 2)));

    assert_blank_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bg_en |=> (pix_idx == 2'b00));

    assert_state_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state));

endmodule

bind bg_pixel_shifter bg_pixel_shifter_chk #(
    .DOT_W(DOT_W), .TILE_W(TILE_W),
    .DRAW_FIRST(DRAW_FIRST), .PRE_FIRST(PRE_FIRST)
) chk_i (
    .clk(clk), .rst_n(rst_n), .dot(dot), .pat_lo(pat_lo), .pat_hi(pat_hi),
    .bg_en(bg_en), .pal_addr(pal_addr), .pix_idx(pix_idx), .pix_valid(pix_valid),
    .plane_lo(plane_q[0]), .plane_hi(plane_q[1]), .state(win_q),
    .shift_en(shift_en), .reload_en(reload_en)
);

// File: tb/bg_pixel_shifter_tb_top.sv
module bg_pixel_shifter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_DOTS  = 341;
    localparam int LINES      = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] dot = '0;
    logic [7:0] pat_lo = '0;
    logic [7:0] pat_hi = '0;
    logic       bg_en = 1'b1;
    logic [1:0] pal_addr;
    logic [1:0] pix_idx;
    logic       pix_valid;

    int checks = 0;
    int errors = 0;
    int line_no = 0;
    bit finished = 0;

    // reference model state
    bit       mq_lo[$];
    bit       mq_hi[$];
    bit [1:0] m_pal = 0;
    bit       m_pal_v = 0;
    bit [1:0] m_pix = 0;
    bit       m_pix_v = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bg_pixel_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .dot(dot), .pat_lo(pat_lo), .pat_hi(pat_hi),
        .bg_en(bg_en), .pal_addr(pal_addr), .pix_idx(pix_idx), .pix_valid(pix_valid)
    );

    function automatic logic [7:0] pat_for(int ln, int d, int plane);
        if (ln == 0) return (d == 329) ? 8'h80 : 8'h00;
        if (ln == 1) return 8'h00;
        return 8'((d * 37 + ln * 91 + plane * 53) & 255);
    endfunction

    function automatic logic en_for(int ln, int d);
        if (ln == 4) return ((d / 16) % 2) == 0;
        return 1'b1;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (line %0d dot %0d)", req, act, exp, line_no, dot);
        end
    endtask

    task automatic model_reset();
        mq_lo.delete(); mq_hi.delete();
        for (int i = 0; i < 16; i++) begin mq_lo.push_back(0); mq_hi.push_back(0); end
        m_pal = 0; m_pal_v = 0; m_pix = 0; m_pix_v = 0;
    endtask

    initial model_reset();

    // behavioural model: pixel queues per plane, front is the next pixel
    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int  d;
            bit  sh, rl;
            d  = int'(dot);
            sh = (d >= 2 && d <= 257) || (d >= 322 && d <= 337);
            rl = sh && (d % 8 == 1);
            m_pix   = (bg_en && m_pal_v) ? m_pal : 2'b00;
            m_pix_v = m_pal_v;
            m_pal_v = sh;
            if (sh) begin
                m_pal = {mq_hi[0], mq_lo[0]};
                void'(mq_lo.pop_front());
                void'(mq_hi.pop_front());
                if (rl) begin
                    while (mq_lo.size() > 8) void'(mq_lo.pop_back());
                    while (mq_hi.size() > 8) void'(mq_hi.pop_back());
                    for (int b = 7; b >= 0; b--) begin
                        mq_lo.push_back(pat_lo[b]);
                        mq_hi.push_back(pat_hi[b]);
                    end
                end else begin
                    mq_lo.push_back(0);
                    mq_hi.push_back(0);
                end
            end
        end
    end

    // compare and drive away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int shown;
            shown = int'(dot) + 1;
            check(pal_addr == m_pal, "R3/R4/R5 pal_addr", pal_addr, m_pal);
            check(pix_valid == m_pix_v, "R2/R7/R9 pix_valid", pix_valid, m_pix_v);
            check(pix_idx == m_pix, en_for(line_no, int'(dot)) ? "R6 pix_idx" : "R8 pix_idx blanked",
                  pix_idx, m_pix);
            if (line_no == 1 && shown == 4)
                check(pix_idx == 2'd3 && pix_valid, "R6 first pixel index 3 at dot 4", pix_idx, 3);
            if (line_no == 1 && shown >= 5 && shown <= 11)
                check(pix_idx == 2'd0 && pix_valid, "R6 trailing pixels index 0", pix_idx, 0);
            if (line_no == 1 && shown == 300)
                check(!pix_valid, "R2 no pixel outside window", pix_valid, 0);
            if (int'(dot) == LINE_DOTS - 1) begin
                dot <= '0;
                line_no <= line_no + 1;
            end else begin
                dot <= dot + 9'd1;
            end
        end
    end

    // input pattern follows the dot and line the design will see next
    always @(negedge clk) begin
        #1;
        pat_lo = pat_for(line_no, int'(dot), 0);
        pat_hi = pat_for(line_no, int'(dot), 1);
        bg_en  = en_for(line_no, int'(dot));
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pal_addr == 2'd0, "R1 reset pal_addr", pal_addr, 0);
        check(pix_idx == 2'd0, "R1 reset pix_idx", pix_idx, 0);
        check(pix_valid == 1'b0, "R1 reset pix_valid", pix_valid, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        wait (line_no == LINES);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule